// File: doc/BRIEF.md
# Permission-Gated Tag Directory

This block is the tag side of a set-associative cache controller. For every way of every set it keeps a line address, an access permission, an occupied flag and a lock-owner context. It also keeps per-set true-LRU ages. A coherence engine drives it one operation per cycle. The operations are: access checks by request kind, plain and permission-blind lookups, an availability query, allocation, deallocation, victim probing, recency touches, permission writes, line locks and a per-way status query. Data storage is kept elsewhere.

Each accepted request produces a registered response one cycle later. The response FSM has two states. ST_IDLE means no response is being presented. ST_RESP means the outputs carry the result of the previous cycle's request. The transitions are: ST_IDLE to ST_RESP on a request (T_ACCEPT), ST_RESP to ST_RESP on a back-to-back request (T_STREAM), and ST_RESP to ST_IDLE when no request arrives (T_DRAIN). The set index comes from `START_BIT` upward. Its width is log2 of the set count, where the set count is capacity divided by ways divided by line bytes and must exceed one.

Top module: `perm_tag_dir`

## Requirements
- R1: A request with `req_valid` high yields `rsp_valid` high on the next cycle. All response fields are zero whenever `rsp_valid` is low. After reset every way is empty (permission code 0), so lookups miss and availability is true.
- R2: A request other than no-op (op 0) or status (op 13) whose address has any non-zero line-offset bit returns `rsp_err`=1 and changes no state.
- R3: The set is selected by address bits `START_BIT` upward. Lines in one set neither occupy nor disturb ways of another set.
- R4: Lookup (op 2) hits only on an occupied matching way whose permission is not not-present (code 0). Lookup-any (op 3) hits on any occupied matching way. On a hit, both return the way and its permission.
- R5: Access (op 1) succeeds on a matching line with permission read-write (code 3). It also succeeds when the permission is read-only (code 2) and the kind is load (0), fetch (1) or speculative load (2). It fails for store (3) on read-only, and for invalid (1), busy (4) or a miss.
- R6: An access, or a touch (op 8), that matches a present line makes that way most recent, even when the permission check fails.
- R7: Availability (op 4) is true when the address occupies a way of its set, or when a way is empty or not-present. Otherwise it is false.
- R8: Allocation (op 5) takes the lowest-numbered empty or not-present way. It stores the address, sets permission invalid, sets the lock owner to all ones, and returns the way. It updates recency only when `req_touch`=1.
- R9: Allocation of a present address or into a full set, and deallocation (op 6) of a non-present address, return `rsp_err`=1 and change nothing. A valid deallocation empties the way. `rsp_ok` and `rsp_err` are never both high.
- R10: Probe (op 7) on a set with no free way returns the address and way of the oldest line, with ties going to the lowest way. Probe on a set with a free way returns an error.
- R11: Lock-set (op 10) stores `req_ctx` as owner. Lock-clear (op 11) stores all ones. Lock-test (op 12) returns ok when the owner equals `req_ctx`. All three error on a non-present line.
- R12: Status (op 13) reports the permission of `req_set`/`req_way` on `rsp_perm`. It sets `rsp_ok` when that permission is invalid and `rsp_busy` when it is busy, and never errors.
- R13: Permission write (op 9) stores `req_perm` into the occupied way that holds the address, whatever its current permission. It errors when no way holds the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Line-aligned address |
| req_kind | input | 2 | Request kind for access checks |
| req_ctx | input | CTX_W | Requester context for lock operations |
| req_perm | input | 3 | Permission for permission writes |
| req_touch | input | 1 | Allocation also updates recency |
| req_set | input | SET_W | Set for status query |
| req_way | input | WAY_W | Way for status query |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Hit / success / available / lock match |
| rsp_err | output | 1 | Precondition violated, no state change |
| rsp_way | output | WAY_W | Way concerned |
| rsp_addr | output | ADDR_W | Victim address on probe |
| rsp_perm | output | 3 | Permission of the way concerned |
| rsp_busy | output | 1 | Status query found busy |

## Verification
An access check and a recency update fall in the same cycle when the permission check fails on a tag match. The bench provokes this with a store to a read-only line, and with a load to an invalid line in a set filled without touching. It then probes the full set and judges from the returned victim that recency moved even though the access failed. A second coincidence is the permission-blind match against the free-slot search. A line set to not-present counts both as held and as free, so availability, deallocation and a probe on that set are each judged against both views.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [2:0] {
        PERM_NP   = 3'd0,
        PERM_INV  = 3'd1,
        PERM_RO   = 3'd2,
        PERM_RW   = 3'd3,
        PERM_BUSY = 3'd4
    } perm_e;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_ACCESS     = 4'd1,
        OP_LOOKUP     = 4'd2,
        OP_LOOKUP_ANY = 4'd3,
        OP_AVAIL      = 4'd4,
        OP_ALLOC      = 4'd5,
        OP_DEALLOC    = 4'd6,
        OP_PROBE      = 4'd7,
        OP_TOUCH      = 4'd8,
        OP_SETPERM    = 4'd9,
        OP_LOCK_SET   = 4'd10,
        OP_LOCK_CLR   = 4'd11,
        OP_LOCK_TEST  = 4'd12,
        OP_STATUS     = 4'd13
    } op_e;

    typedef enum logic [1:0] {
        RQ_LOAD   = 2'd0,
        RQ_FETCH  = 2'd1,
        RQ_SPEC   = 2'd2,
        RQ_STORE  = 2'd3
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/tagdir_match.sv
module tagdir_match
    import tagdir_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             occ,
    input  logic [WAYS-1:0][2:0]        perm,
    input  logic [WAYS-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]           key,
    output logic                        any_hit,
    output logic [WAY_W-1:0]            any_way,
    output logic                        gated_hit,
    output logic [WAY_W-1:0]            gated_way,
    output logic                        free_any,
    output logic [WAY_W-1:0]            free_way
);
    logic [WAYS-1:0] any_v, gated_v, free_v;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign any_v[w]   = occ[w] && (tags[w] == key);
        assign gated_v[w] = any_v[w] && (perm[w] != PERM_NP);
        assign free_v[w]  = !occ[w] || (perm[w] == PERM_NP);
    end

    assign any_hit   = |any_v;
    assign gated_hit = |gated_v;
    assign free_any  = |free_v;

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        any_way   = '0;
        gated_way = '0;
        free_way  = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (any_v[i])   any_way   = WAY_W'(i);
            if (gated_v[i]) gated_way = WAY_W'(i);
            if (free_v[i])  free_way  = WAY_W'(i);
        end
    end
endmodule

// File: rtl/tagdir_lru_set.sv
module tagdir_lru_set #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);
    // age 0 is most recent; WAYS-1 is oldest
    logic [WAYS-1:0][WAY_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= {WAYS{WAY_W'(WAYS - 1)}};
        end else if (touch_en) begin
            for (int i = 0; i < WAYS; i++) begin
                if (WAY_W'(i) == touch_way)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_way])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic [WAY_W-1:0] best_age;
        victim   = '0;
        best_age = age_q[0];
        for (int i = 1; i < WAYS; i++) begin
            if (age_q[i] > best_age) begin
                victim   = WAY_W'(i);
                best_age = age_q[i];
            end
        end
    end
endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir
    import tagdir_pkg::*;
#(
    parameter int CACHE_BYTES = 1024,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 64,
    parameter int ADDR_W      = 16,
    parameter int START_BIT   = 6,
    parameter int CTX_W       = 4,
    localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [2:0]        req_perm,
    input  logic              req_touch,
    input  logic [SET_W-1:0]  req_set,
    input  logic [WAY_W-1:0]  req_way,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_err,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [2:0]        rsp_perm,
    output logic              rsp_busy
);
    localparam logic [CTX_W-1:0] NO_OWNER = '1;

    // directory storage
    logic [WAYS-1:0]             occ_q  [SETS];
    logic [WAYS-1:0][2:0]        perm_q [SETS];
    logic [WAYS-1:0][ADDR_W-1:0] tag_q  [SETS];
    logic [WAYS-1:0][CTX_W-1:0]  lock_q [SETS];

    logic [SET_W-1:0] cur_set;
    assign cur_set = req_addr[START_BIT +: SET_W];

    logic             a_hit, g_hit, f_any;
    logic [WAY_W-1:0] a_way, g_way, f_way;

    tagdir_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
        .occ       (occ_q[cur_set]),
        .perm      (perm_q[cur_set]),
        .tags      (tag_q[cur_set]),
        .key       (req_addr),
        .any_hit   (a_hit),
        .any_way   (a_way),
        .gated_hit (g_hit),
        .gated_way (g_way),
        .free_any  (f_any),
        .free_way  (f_way)
    );

    logic             touch_en;
    logic [WAY_W-1:0] touch_way;
    logic [WAY_W-1:0] victim_w [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_lru
        tagdir_lru_set #(.WAYS(WAYS)) u_lru (
            .clk       (clk),
            .rst_n     (rst_n),
            .touch_en  (touch_en && (cur_set == SET_W'(s))),
            .touch_way (touch_way),
            .victim    (victim_w[s])
        );
    end

    // operation decode
    logic              occ_we, perm_we, tag_we, lock_we;
    logic [WAY_W-1:0]  wr_way;
    logic              new_occ;
    logic [2:0]        new_perm;
    logic [CTX_W-1:0]  new_lock;
    logic              d_ok, d_err, d_busy;
    logic [WAY_W-1:0]  d_way;
    logic [ADDR_W-1:0] d_addr;
    logic [2:0]        d_perm;
    logic              misaligned;
    logic [2:0]        g_perm;
    logic [WAY_W-1:0]  cur_vic;

    assign g_perm  = perm_q[cur_set][g_way];
    assign cur_vic = victim_w[cur_set];
    assign misaligned = (req_addr[OFF_W-1:0] != '0)
                        && (req_op != OP_NOP) && (req_op != OP_STATUS);

    always_comb begin
        occ_we = 1'b0; perm_we = 1'b0; tag_we = 1'b0; lock_we = 1'b0;
        wr_way = g_way; new_occ = 1'b0; new_perm = PERM_NP; new_lock = NO_OWNER;
        touch_en = 1'b0; touch_way = g_way;
        d_ok = 1'b0; d_err = 1'b0; d_busy = 1'b0;
        d_way = '0; d_addr = '0; d_perm = '0;
        if (req_valid) begin
            if (misaligned) begin
                d_err = 1'b1;
            end else begin
                case (req_op)
                    OP_ACCESS: if (g_hit) begin
                        touch_en = 1'b1;
                        d_way    = g_way;
                        d_perm   = g_perm;
                        d_ok     = (g_perm == PERM_RW)
                                   || ((g_perm == PERM_RO) && (req_kind != RQ_STORE));
                    end
                    OP_LOOKUP: if (g_hit) begin
                        d_ok = 1'b1; d_way = g_way; d_perm = g_perm;
                    end
                    OP_LOOKUP_ANY: if (a_hit) begin
                        d_ok = 1'b1; d_way = a_way; d_perm = perm_q[cur_set][a_way];
                    end
                    OP_AVAIL: d_ok = a_hit || f_any;
                    OP_ALLOC: if (g_hit || !f_any) begin
                        d_err = 1'b1;
                    end else begin
                        occ_we = 1'b1; perm_we = 1'b1; tag_we = 1'b1; lock_we = 1'b1;
                        wr_way = f_way; new_occ = 1'b1; new_perm = PERM_INV;
                        touch_en = req_touch; touch_way = f_way;
                        d_ok = 1'b1; d_way = f_way; d_perm = PERM_INV;
                    end
                    OP_DEALLOC: if (!g_hit) begin
                        d_err = 1'b1;
                    end else begin
                        occ_we = 1'b1; perm_we = 1'b1; lock_we = 1'b1;
                        d_ok = 1'b1; d_way = g_way;
                    end
                    OP_PROBE: if (a_hit || f_any) begin
                        d_err = 1'b1;
                    end else begin
                        d_ok = 1'b1; d_way = cur_vic;
                        d_addr = tag_q[cur_set][cur_vic];
                        d_perm = perm_q[cur_set][cur_vic];
                    end
                    OP_TOUCH: if (g_hit) begin
                        touch_en = 1'b1; d_ok = 1'b1; d_way = g_way;
                    end
                    OP_SETPERM: if (!a_hit) begin
                        d_err = 1'b1;
                    end else begin
                        perm_we = 1'b1; wr_way = a_way; new_perm = req_perm;
                        d_ok = 1'b1; d_way = a_way; d_perm = req_perm;
                    end
                    OP_LOCK_SET, OP_LOCK_CLR: if (!g_hit) begin
                        d_err = 1'b1;
                    end else begin
                        lock_we  = 1'b1;
                        new_lock = (req_op == OP_LOCK_SET) ? req_ctx : NO_OWNER;
                        d_ok = 1'b1; d_way = g_way;
                    end
                    OP_LOCK_TEST: if (!g_hit) begin
                        d_err = 1'b1;
                    end else begin
                        d_ok  = (lock_q[cur_set][g_way] == req_ctx);
                        d_way = g_way;
                    end
                    OP_STATUS: begin
                        d_perm = perm_q[req_set][req_way];
                        d_ok   = (d_perm == PERM_INV);
                        d_busy = (d_perm == PERM_BUSY);
                        d_way  = req_way;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                occ_q[s]  <= '0;
                perm_q[s] <= '0;
                tag_q[s]  <= '0;
                lock_q[s] <= {WAYS{NO_OWNER}};
            end
        end else begin
            if (occ_we)  occ_q[cur_set][wr_way]  <= new_occ;
            if (perm_we) perm_q[cur_set][wr_way] <= new_perm;
            if (tag_we)  tag_q[cur_set][wr_way]  <= req_addr;
            if (lock_we) lock_q[cur_set][wr_way] <= new_lock;
        end
    end

    // response FSM: state register
    rsp_state_e state_q, state_d;
    logic              q_ok, q_err, q_busy;
    logic [WAY_W-1:0]  q_way;
    logic [ADDR_W-1:0] q_addr;
    logic [2:0]        q_perm;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;   // T_ACCEPT
            ST_RESP: if (!req_valid) state_d = ST_IDLE;   // T_DRAIN, else T_STREAM
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            q_ok <= 1'b0; q_err <= 1'b0; q_busy <= 1'b0;
            q_way <= '0; q_addr <= '0; q_perm <= '0;
        end else begin
            state_q <= state_d;
            q_ok <= d_ok; q_err <= d_err; q_busy <= d_busy;
            q_way <= d_way; q_addr <= d_addr; q_perm <= d_perm;
        end
    end

    // response FSM: outputs
    always_comb begin
        rsp_valid = 1'b0; rsp_ok = 1'b0; rsp_err = 1'b0; rsp_busy = 1'b0;
        rsp_way = '0; rsp_addr = '0; rsp_perm = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid = 1'b1; rsp_ok = q_ok; rsp_err = q_err; rsp_busy = q_busy;
                rsp_way = q_way; rsp_addr = q_addr; rsp_perm = q_perm;
            end
        endcase
    end
endmodule

// File: rtl/tagdir_checker.sv
module tagdir_checker
    import tagdir_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 64,
    parameter int WAY_W      = 2,
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              rsp_err,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_busy
);
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1

    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_ok && !rsp_err && !rsp_busy
                        && rsp_addr == '0 && rsp_way == '0)); // R1

    AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != OP_NOP && req_op != OP_STATUS
         && req_addr[OFF_W-1:0] != '0) |=> (rsp_err && !rsp_ok)); // R2

    AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_ok && rsp_err)); // R9

    AST_QUERY_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[OFF_W-1:0] == '0
         && (req_op == OP_LOOKUP || req_op == OP_LOOKUP_ANY
             || req_op == OP_AVAIL || req_op == OP_ACCESS))
        |=> !rsp_err); // R4

    AST_STATUS_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_STATUS) |=> !rsp_err); // R12

    AST_BUSY_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != OP_STATUS) |=> !rsp_busy); // R12
endmodule

bind perm_tag_dir tagdir_checker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WAY_W(WAY_W)
) u_tagdir_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_err(rsp_err), .rsp_way(rsp_way), .rsp_addr(rsp_addr),
    .rsp_busy(rsp_busy)
);

// File: tb/test_perm_tag_dir.sv
`timescale 1ns/1ps
module test_perm_tag_dir;
    import tagdir_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, req_valid, req_touch;
    logic [3:0]  req_op, req_ctx;
    logic [15:0] req_addr;
    logic [1:0]  req_kind, req_set, req_way;
    logic [2:0]  req_perm;
    logic        rsp_valid, rsp_ok, rsp_err, rsp_busy;
    logic [1:0]  rsp_way;
    logic [15:0] rsp_addr;
    logic [2:0]  rsp_perm;

    perm_tag_dir i_perm_tag_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_kind(req_kind), .req_ctx(req_ctx),
        .req_perm(req_perm), .req_touch(req_touch), .req_set(req_set),
        .req_way(req_way), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_err(rsp_err), .rsp_way(rsp_way), .rsp_addr(rsp_addr),
        .rsp_perm(rsp_perm), .rsp_busy(rsp_busy)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // chk: 0 flags only, 1 way, 2 probe address, 3 permission
    typedef struct packed {
        logic [3:0]  rq;
        logic [3:0]  op;
        logic [15:0] addr;
        logic [3:0]  arg;
        logic        ok;
        logic        err;
        logic [1:0]  chk;
        logic [15:0] aux;
    } vec_t;

    localparam int NV = 64;
    localparam vec_t VT [NV] = '{
        '{4'd7,  OP_AVAIL,      16'h0100, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0},   // R7 empty
        '{4'd4,  OP_LOOKUP,     16'h0100, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0},   // R4
        '{4'd8,  OP_ALLOC,      16'h0100, 4'd1, 1'b1, 1'b0, 2'd1, 16'd0},   // R8
        '{4'd8,  OP_LOOKUP,     16'h0100, 4'd0, 1'b1, 1'b0, 2'd3, 16'd1},   // R8 invalid
        '{4'd9,  OP_ALLOC,      16'h0100, 4'd1, 1'b0, 1'b1, 2'd0, 16'h0},   // R9 dup
        '{4'd5,  OP_ACCESS,     16'h0100, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0},   // R5 invalid
        '{4'd13, OP_SETPERM,    16'h0100, 4'd2, 1'b1, 1'b0, 2'd0, 16'h0},   // R13
        '{4'd5,  OP_ACCESS,     16'h0100, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0},   // R5 RO load
        '{4'd5,  OP_ACCESS,     16'h0100, 4'd1, 1'b1, 1'b0, 2'd0, 16'h0},   // R5 RO fetch
        '{4'd5,  OP_ACCESS,     16'h0100, 4'd2, 1'b1, 1'b0, 2'd0, 16'h0},   // R5 RO spec
        '{4'd5,  OP_ACCESS,     16'h0100, 4'd3, 1'b0, 1'b0, 2'd0, 16'h0},   // R5 RO store
        '{4'd13, OP_SETPERM,    16'h0100, 4'd3, 1'b1, 1'b0, 2'd0, 16'h0},   // R13
        '{4'd5,  OP_ACCESS,     16'h0100, 4'd3, 1'b1, 1'b0, 2'd1, 16'd0},   // R5 RW store
        '{4'd8,  OP_ALLOC,      16'h0200, 4'd1, 1'b1, 1'b0, 2'd1, 16'd1},   // R8
        '{4'd8,  OP_ALLOC,      16'h0300, 4'd1, 1'b1, 1'b0, 2'd1, 16'd2},   // R8
        '{4'd8,  OP_ALLOC,      16'h0400, 4'd1, 1'b1, 1'b0, 2'd1, 16'd3},   // R8
        '{4'd7,  OP_AVAIL,      16'h0500, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0},   // R7 full
        '{4'd7,  OP_AVAIL,      16'h0100, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0},   // R7 present
        '{4'd9,  OP_ALLOC,      16'h0500, 4'd1, 1'b0, 1'b1, 2'd0, 16'h0},   // R9 full
        '{4'd10, OP_PROBE,      16'h0500, 4'd0, 1'b1, 1'b0, 2'd2, 16'h0100},// R10
        '{4'd6,  OP_ACCESS,     16'h0100, 4'd3, 1'b1, 1'b0, 2'd0, 16'h0},   // R6
        '{4'd6,  OP_PROBE,      16'h0500, 4'd0, 1'b1, 1'b0, 2'd2, 16'h0200},// R6
        '{4'd13, OP_SETPERM,    16'h0200, 4'd2, 1'b1, 1'b0, 2'd0, 16'h0},   // R13
        '{4'd6,  OP_ACCESS,     16'h0200, 4'd3, 1'b0, 1'b0, 2'd0, 16'h0},   // R6 failed
        '{4'd6,  OP_PROBE,      16'h0500, 4'd0, 1'b1, 1'b0, 2'd2, 16'h0300},// R6 moved
        '{4'd13, OP_SETPERM,    16'h0300, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0},   // R13 to NP
        '{4'd4,  OP_LOOKUP,     16'h0300, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0},   // R4 gated
        '{4'd4,  OP_LOOKUP_ANY, 16'h0300, 4'd0, 1'b1, 1'b0, 2'd1, 16'd2},   // R4 blind
        '{4'd7,  OP_AVAIL,      16'h0500, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0},   // R7 NP free
        '{4'd9,  OP_DEALLOC,    16'h0300, 4'd0, 1'b0, 1'b1, 2'd0, 16'h0},   // R9
        '{4'd10, OP_PROBE,      16'h0500, 4'd0, 1'b0, 1'b1, 2'd0, 16'h0},   // R10 avail
        '{4'd8,  OP_ALLOC,      16'h0500, 4'd0, 1'b1, 1'b0, 2'd1, 16'd2},   // R8 NP reuse
        '{4'd4,  OP_LOOKUP,     16'h0500, 4'd0, 1'b1, 1'b0, 2'd1, 16'd2},   // R4
        '{4'd4,  OP_LOOKUP_ANY, 16'h0300, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0},   // R4
        '{4'd8,  OP_PROBE,      16'h0600, 4'd0, 1'b1, 1'b0, 2'd2, 16'h0500},// R8 no touch
        '{4'd8,  OP_LOCK_TEST,  16'h0100, 4'd15,1'b1, 1'b0, 2'd0, 16'h0},   // R8 owner
        '{4'd11, OP_LOCK_SET,   16'h0100, 4'd5, 1'b1, 1'b0, 2'd0, 16'h0},   // R11
        '{4'd11, OP_LOCK_TEST,  16'h0100, 4'd5, 1'b1, 1'b0, 2'd0, 16'h0},   // R11
        '{4'd11, OP_LOCK_TEST,  16'h0100, 4'd3, 1'b0, 1'b0, 2'd0, 16'h0},   // R11
        '{4'd11, OP_LOCK_CLR,   16'h0100, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0},   // R11
        '{4'd11, OP_LOCK_TEST,  16'h0100, 4'd5, 1'b0, 1'b0, 2'd0, 16'h0},   // R11
        '{4'd11, OP_LOCK_SET,   16'h0600, 4'd2, 1'b0, 1'b1, 2'd0, 16'h0},   // R11 absent
        '{4'd9,  OP_DEALLOC,    16'h0400, 4'd0, 1'b1, 1'b0, 2'd1, 16'd3},   // R9
        '{4'd9,  OP_LOOKUP_ANY, 16'h0400, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0},   // R9 emptied
        '{4'd7,  OP_AVAIL,      16'h0600, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0},   // R7
        '{4'd9,  OP_DEALLOC,    16'h0400, 4'd0, 1'b0, 1'b1, 2'd0, 16'h0},   // R9
        '{4'd8,  OP_ALLOC,      16'h0600, 4'd1, 1'b1, 1'b0, 2'd1, 16'd3},   // R8
        '{4'd2,  OP_ALLOC,      16'h0141, 4'd1, 1'b0, 1'b1, 2'd0, 16'h0},   // R2
        '{4'd3,  OP_ALLOC,      16'h0140, 4'd1, 1'b1, 1'b0, 2'd1, 16'd0},   // R3 set1
        '{4'd3,  OP_LOOKUP,     16'h0100, 4'd0, 1'b1, 1'b0, 2'd1, 16'd0},   // R3 set0
        '{4'd12, OP_STATUS,     16'h0000, 4'd1, 1'b0, 1'b0, 2'd3, 16'd2},   // R12 RO
        '{4'd13, OP_SETPERM,    16'h0100, 4'd4, 1'b1, 1'b0, 2'd0, 16'h0},   // R13 busy
        '{4'd12, OP_STATUS,     16'h0000, 4'd0, 1'b0, 1'b0, 2'd3, 16'd4},   // R12 busy
        '{4'd5,  OP_ACCESS,     16'h0100, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0},   // R5 busy
        '{4'd12, OP_STATUS,     16'h0040, 4'd0, 1'b1, 1'b0, 2'd3, 16'd1},   // R12 inv
        '{4'd13, OP_SETPERM,    16'h0900, 4'd3, 1'b0, 1'b1, 2'd0, 16'h0},   // R13 absent
        '{4'd6,  OP_TOUCH,      16'h0900, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0},   // R6
        '{4'd6,  OP_TOUCH,      16'h0200, 4'd0, 1'b1, 1'b0, 2'd1, 16'd1},   // R6
        '{4'd8,  OP_ALLOC,      16'h0180, 4'd0, 1'b1, 1'b0, 2'd1, 16'd0},   // R8 set2
        '{4'd8,  OP_ALLOC,      16'h0280, 4'd0, 1'b1, 1'b0, 2'd1, 16'd1},   // R8
        '{4'd8,  OP_ALLOC,      16'h0380, 4'd0, 1'b1, 1'b0, 2'd1, 16'd2},   // R8
        '{4'd8,  OP_ALLOC,      16'h0480, 4'd0, 1'b1, 1'b0, 2'd1, 16'd3},   // R8
        '{4'd10, OP_PROBE,      16'h0580, 4'd0, 1'b1, 1'b0, 2'd2, 16'h0180},// R10 tie
        '{4'd6,  OP_ACCESS,     16'h0180, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0}   // R6 touch
    };

    task automatic issue(input logic [3:0] op, input logic [15:0] addr, input logic [3:0] arg);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_kind = arg[1:0]; req_ctx = arg; req_perm = arg[2:0];
        req_touch = arg[0]; req_set = addr[7:6]; req_way = arg[1:0];
        @(negedge clk);
        req_valid = 1'b0; req_op = 4'd0;
    endtask

    task automatic judge(input logic [3:0] rq, input logic [3:0] op, input logic e_ok,
                         input logic e_err, input logic [1:0] chk, input logic [15:0] aux);
        logic good;
        logic e_busy;
        e_busy = (op == OP_STATUS) && (aux == 16'd4);
        good = rsp_valid && (rsp_ok == e_ok) && (rsp_err == e_err) && (rsp_busy == e_busy);
        if (chk == 2'd1) good = good && (rsp_way == aux[1:0]);
        if (chk == 2'd2) good = good && (rsp_addr == aux);
        if (chk == 2'd3) good = good && (rsp_perm == aux[2:0]);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL R%0d op %0d: got v%0b ok%0b err%0b busy%0b way%0d addr %h perm %0d; exp ok%0b err%0b busy%0b chk%0d aux %h",
                     rq, op, rsp_valid, rsp_ok, rsp_err, rsp_busy, rsp_way, rsp_addr, rsp_perm,
                     e_ok, e_err, e_busy, chk, aux);
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_kind = '0;
        req_ctx = '0; req_perm = '0; req_touch = 1'b0; req_set = '0; req_way = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, no response presented
        checks++;
        if (rsp_valid || rsp_ok || rsp_err || rsp_addr != 16'h0) begin
            errors++;
            $display("FAIL R1 reset: valid %0b ok %0b err %0b addr %h, exp all zero",
                     rsp_valid, rsp_ok, rsp_err, rsp_addr);
        end

        for (int i = 0; i < NV; i++) begin
            issue(VT[i].op, VT[i].addr, VT[i].arg);
            judge(VT[i].rq, VT[i].op, VT[i].ok, VT[i].err, VT[i].chk, VT[i].aux);
        end

        // R6: the failed load above still touched way 0 of set 2
        issue(OP_PROBE, 16'h0580, 4'd0);
        judge(4'd6, OP_PROBE, 1'b1, 1'b0, 2'd2, 16'h0280);

        // R1: idle cycle returns to no response
        @(negedge clk);
        checks++;
        if (rsp_valid) begin
            errors++;
            $display("FAIL R1 idle: valid %0b, exp 0", rsp_valid);
        end

        // R1: reset empties the directory
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        issue(OP_LOOKUP_ANY, 16'h0100, 4'd0);
        judge(4'd1, OP_LOOKUP_ANY, 1'b0, 1'b0, 2'd0, 16'h0);
        issue(OP_AVAIL, 16'h0500, 4'd0);
        judge(4'd1, OP_AVAIL, 1'b1, 1'b0, 2'd0, 16'h0);
        // R2: misaligned deallocation after reset is refused
        issue(OP_DEALLOC, 16'h0102, 4'd0);
        judge(4'd2, OP_DEALLOC, 1'b0, 1'b1, 2'd0, 16'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule